// File: doc/BRIEF.md
# Context-Tagged Fully Associative Translation Buffer

This block translates a 32-bit virtual address into a 31-bit physical address for one of 256 address contexts. It holds 32 translations, and a lookup compares all of them at once. Each stored translation covers a 4 KB page. The block maps the 20-bit virtual page number together with the 8-bit context number to a 19-bit physical page number, a 3-bit selector that picks one of 8 physical address spaces, and four permission bits. The 12-bit page offset passes through unchanged.

A lookup request presents an address, a context, an access kind and the privilege of the requester. One cycle later the block reports the result: a hit or a miss, a protection fault, or a valid translated address. After a miss, a table-walk sequencer outside the block loads the translation through the fill port. The block chooses the slot for the new entry itself. It first takes an entry that already holds the same page and context, then the lowest free entry, then the entry named by a round-robin pointer. Flush inputs remove every entry, or only the entries of one context.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid and all lookup outputs are 0, so the first lookup after reset misses.
- R2: A lookup request in a cycle produces `lk_done` high in the next cycle, with the result in the same cycle. A cycle without a request produces `lk_done`, `lk_hit`, `lk_fault` and `pa_valid` low in the next cycle.
- R3: A lookup hits only on a valid entry whose page number equals `lk_vaddr[31:12]`. On a hit without a fault, `pa` = {entry page, `lk_vaddr[11:0]`} and `pa_space` is the entry's selector. On a miss or a fault, `pa` and `pa_space` read 0.
- R4: The entry's context must also equal `lk_ctx`. The same page under another context misses.
- R5: Permission bits `fl_perm` are {supervisor-only, execute, write, read} from bit 3 down to bit 0. The access code `lk_acc` selects the bit that must be set: 0 = read needs bit 0, 1 = write needs bit 1, 2 = execute needs bit 2. Code 3 always faults. An entry with bit 3 set faults unless `lk_super` is 1. A fault gives `lk_hit`=1, `lk_fault`=1 and `pa_valid`=0.
- R6: A fill with no matching entry takes the lowest-index invalid entry. When all entries are valid, it replaces the entry named by a round-robin pointer. The pointer starts at 0, advances by one only on such a replacement, and wraps from 31 to 0.
- R7: A fill whose page and context match a valid entry overwrites that entry, so no two valid entries ever hold the same page and context.
- R8: `fsh_all` invalidates every entry. `fsh_ctx_en` invalidates only the entries whose context equals `fsh_ctx` and leaves the others usable.
- R9: A fill in the same cycle as either flush is dropped.
- R10: At most one entry matches a lookup. If more than one matched, the lowest index would be used.
- R11: A lookup in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_ctx | input | 8 | Context of the lookup |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 illegal |
| lk_super | input | 1 | Requester is privileged |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | 20 | Virtual page number to load |
| fl_ctx | input | 8 | Context of the loaded entry |
| fl_ppn | input | 19 | Physical page number to load |
| fl_space | input | 3 | Address-space selector to load |
| fl_perm | input | 4 | Permissions {sup, exec, write, read} |
| fsh_all | input | 1 | Invalidate all entries |
| fsh_ctx_en | input | 1 | Invalidate the entries of one context |
| fsh_ctx | input | 8 | Context to invalidate |
| lk_done | output | 1 | Lookup result is valid this cycle |
| lk_hit | output | 1 | An entry matched |
| lk_fault | output | 1 | Match that breaks the permissions |
| pa_valid | output | 1 | Translated address is usable |
| pa | output | 31 | Physical address |
| pa_space | output | 3 | Physical address-space selector |

## Verification
The assertions check the following on every cycle:
- At most one entry matches a lookup, and at most one entry matches a fill.
- A fault never comes with a usable address.
- A result follows each request by exactly one cycle, and idle cycles stay quiet.
- A usable address carries the requested offset.
- A fill into a non-full buffer lands on a free entry.
- A full flush empties the buffer.

Only the bench scenarios show the rest. These cover the choice of the lowest free slot after a per-context flush, the order of round-robin evictions and their wrap, the overwrite of an existing page, the ordering when a lookup, fill or flush happens in the same cycle, and the complete permission matrix.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_BAD   = 2'd3
  } acc_t;

  localparam int PERM_W  = 4;
  localparam int PRM_RD  = 0;
  localparam int PRM_WR  = 1;
  localparam int PRM_EX  = 2;
  localparam int PRM_SUP = 3;
endpackage

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  acc_t              acc,
  input  logic              super_mode,
  input  logic [PERM_W-1:0] perm,
  output logic              viol
);
  logic granted;

  always_comb begin
    unique case (acc)
      ACC_READ:  granted = perm[PRM_RD];
      ACC_WRITE: granted = perm[PRM_WR];
      ACC_EXEC:  granted = perm[PRM_EX];
      default:   granted = 1'b0;
    endcase
    viol = !granted || (perm[PRM_SUP] && !super_mode);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fill_req,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] fill_hit_vec,
  output logic [IDX_W-1:0]   wr_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_hit;
  logic             any_free;
  logic             evict;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_hit_vec[i]) hit_idx = IDX_W'(i);
      if (!valid_vec[i])   free_idx = IDX_W'(i);
    end
    any_hit  = |fill_hit_vec;
    any_free = !(&valid_vec);
    evict    = !any_hit && !any_free;
    if (any_hit)       wr_idx = hit_idx;
    else if (any_free) wr_idx = free_idx;
    else               wr_idx = ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (fill_req && evict) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  AST_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !any_hit && any_free) |-> !valid_vec[wr_idx]); // R6

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fill_req |=> $stable(ptr)); // R6
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int CTX_W   = 8,
  parameter int PPN_W   = 19,
  parameter int SPC_W   = 3,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [CTX_W-1:0]   lk_ctx,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [CTX_W-1:0]   wr_ctx,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic [SPC_W-1:0]   wr_space,
  input  logic [PERM_W-1:0]  wr_perm,
  input  logic               flush_all,
  input  logic               flush_ctx_en,
  input  logic [CTX_W-1:0]   flush_ctx,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] fill_hit_vec,
  output logic               hit_any,
  output logic [PPN_W-1:0]   hit_ppn,
  output logic [SPC_W-1:0]   hit_space,
  output logic [PERM_W-1:0]  hit_perm
);
  logic [VPN_W-1:0]  e_vpn   [ENTRIES];
  logic [CTX_W-1:0]  e_ctx   [ENTRIES];
  logic [PPN_W-1:0]  e_ppn   [ENTRIES];
  logic [SPC_W-1:0]  e_space [ENTRIES];
  logic [PERM_W-1:0] e_perm  [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g]      = valid_vec[g] && (e_vpn[g] == lk_vpn) && (e_ctx[g] == lk_ctx);
    assign fill_hit_vec[g] = valid_vec[g] && (e_vpn[g] == wr_vpn) && (e_ctx[g] == wr_ctx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_all || (flush_ctx_en && e_ctx[i] == flush_ctx))
          valid_vec[i] <= 1'b0;
        else if (wr_en && wr_idx == IDX_W'(i))
          valid_vec[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en && wr_idx == IDX_W'(i)) begin
        e_vpn[i]   <= wr_vpn;
        e_ctx[i]   <= wr_ctx;
        e_ppn[i]   <= wr_ppn;
        e_space[i] <= wr_space;
        e_perm[i]  <= wr_perm;
      end
    end
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = IDX_W'(i);
    end
    hit_any   = |hit_vec;
    hit_ppn   = e_ppn[sel];
    hit_space = e_space[sel];
    hit_perm  = e_perm[sel];
  end

  AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R10

  AST_FILL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fill_hit_vec)); // R7

  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (valid_vec == '0)); // R8

  AST_WRITE_SETS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_vec[$past(wr_idx)]); // R6
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PA_W    = 31,
  parameter int PG_W    = 12,
  parameter int CTX_W   = 8,
  parameter int SPC_W   = 3,
  localparam int VPN_W  = VA_W - PG_W,
  localparam int PPN_W  = PA_W - PG_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic [1:0]        lk_acc,
  input  logic              lk_super,
  input  logic              fl_valid,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [CTX_W-1:0]  fl_ctx,
  input  logic [PPN_W-1:0]  fl_ppn,
  input  logic [SPC_W-1:0]  fl_space,
  input  logic [PERM_W-1:0] fl_perm,
  input  logic              fsh_all,
  input  logic              fsh_ctx_en,
  input  logic [CTX_W-1:0]  fsh_ctx,
  output logic              lk_done,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic              pa_valid,
  output logic [PA_W-1:0]   pa,
  output logic [SPC_W-1:0]  pa_space
);
  logic               fill_req;
  logic [IDX_W-1:0]   wr_idx;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] fill_hit_vec;
  logic               hit_any;
  logic [PPN_W-1:0]   hit_ppn;
  logic [SPC_W-1:0]   hit_space;
  logic [PERM_W-1:0]  hit_perm;
  logic               viol;
  logic               good;

  assign fill_req = fl_valid && !fsh_all && !fsh_ctx_en;

  tlb_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W), .PPN_W(PPN_W), .SPC_W(SPC_W)
  ) u_array (
    .clk(clk), .rst(rst),
    .lk_vpn(lk_vaddr[VA_W-1:PG_W]), .lk_ctx(lk_ctx),
    .wr_en(fill_req), .wr_idx(wr_idx),
    .wr_vpn(fl_vpn), .wr_ctx(fl_ctx), .wr_ppn(fl_ppn),
    .wr_space(fl_space), .wr_perm(fl_perm),
    .flush_all(fsh_all), .flush_ctx_en(fsh_ctx_en), .flush_ctx(fsh_ctx),
    .valid_vec(valid_vec), .fill_hit_vec(fill_hit_vec),
    .hit_any(hit_any), .hit_ppn(hit_ppn), .hit_space(hit_space), .hit_perm(hit_perm)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .fill_req(fill_req),
    .valid_vec(valid_vec), .fill_hit_vec(fill_hit_vec), .wr_idx(wr_idx)
  );

  tlb_perm u_perm (
    .acc(acc_t'(lk_acc)), .super_mode(lk_super), .perm(hit_perm), .viol(viol)
  );

  assign good = lk_valid && hit_any && !viol;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done  <= 1'b0;
      lk_hit   <= 1'b0;
      lk_fault <= 1'b0;
      pa_valid <= 1'b0;
      pa       <= '0;
      pa_space <= '0;
    end else begin
      lk_done  <= lk_valid;
      lk_hit   <= lk_valid && hit_any;
      lk_fault <= lk_valid && hit_any && viol;
      pa_valid <= good;
      pa       <= good ? {hit_ppn, lk_vaddr[PG_W-1:0]} : '0;
      pa_space <= good ? hit_space : '0;
    end
  end

  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> (lk_hit && !pa_valid)); // R5

  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_done); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!lk_done && !lk_hit && !pa_valid)); // R2

  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (rst)
    pa_valid |-> (pa[PG_W-1:0] == $past(lk_vaddr[PG_W-1:0]))); // R3
endmodule

// File: tb/sim_ctx_tlb.sv
module sim_ctx_tlb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0;
  logic [31:0] lk_vaddr = 0;
  logic [7:0]  lk_ctx = 0;
  logic [1:0]  lk_acc = 0;
  logic        lk_super = 0;
  logic        fl_valid = 0;
  logic [19:0] fl_vpn = 0;
  logic [7:0]  fl_ctx = 0;
  logic [18:0] fl_ppn = 0;
  logic [2:0]  fl_space = 0;
  logic [3:0]  fl_perm = 0;
  logic        fsh_all = 0;
  logic        fsh_ctx_en = 0;
  logic [7:0]  fsh_ctx = 0;
  logic        lk_done, lk_hit, lk_fault, pa_valid;
  logic [30:0] pa;
  logic [2:0]  pa_space;

  always #10 clk = ~clk;

  ctx_tlb u0 (.*);

  typedef struct packed {
    logic        hit;
    logic        fault;
    logic        pav;
    logic [30:0] pa;
    logic [2:0]  sp;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  bit          mv   [N];
  logic [19:0] mvpn [N];
  logic [7:0]  mctx [N];
  logic [18:0] mppn [N];
  logic [2:0]  msp  [N];
  logic [3:0]  mprm [N];
  int          mptr = 0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model_lk(logic [31:0] va, logic [7:0] c, logic [1:0] acc, logic sup);
    exp_t e = '0;
    int   k = -1;
    bit   need;
    for (int i = N - 1; i >= 0; i--)
      if (mv[i] && mvpn[i] == va[31:12] && mctx[i] == c) k = i;
    if (k < 0) return e;
    case (acc)
      2'd0: need = mprm[k][0];
      2'd1: need = mprm[k][1];
      2'd2: need = mprm[k][2];
      default: need = 0;
    endcase
    e.hit = 1;
    if (!need || (mprm[k][3] && !sup)) begin
      e.fault = 1;
    end else begin
      e.pav = 1;
      e.pa  = {mppn[k], va[11:0]};
      e.sp  = msp[k];
    end
    return e;
  endfunction

  function automatic void model_fill(logic [19:0] v, logic [7:0] c, logic [18:0] p,
                                     logic [2:0] s, logic [3:0] pr);
    int k = -1;
    for (int i = N - 1; i >= 0; i--)
      if (mv[i] && mvpn[i] == v && mctx[i] == c) k = i;
    if (k < 0)
      for (int i = N - 1; i >= 0; i--)
        if (!mv[i]) k = i;
    if (k < 0) begin
      k = mptr;
      mptr = (mptr + 1) % N;
    end
    mv[k] = 1; mvpn[k] = v; mctx[k] = c; mppn[k] = p; msp[k] = s; mprm[k] = pr;
  endfunction

  task automatic set_lookup(input logic [31:0] va, input logic [7:0] c,
                            input logic [1:0] acc, input logic sup, input string tag);
    lk_valid = 1; lk_vaddr = va; lk_ctx = c; lk_acc = acc; lk_super = sup;
    exp_q.push_back(model_lk(va, c, acc, sup));
    tag_q.push_back(tag);
  endtask

  task automatic set_fill(input logic [19:0] v, input logic [7:0] c, input logic [18:0] p,
                          input logic [2:0] s, input logic [3:0] pr);
    fl_valid = 1; fl_vpn = v; fl_ctx = c; fl_ppn = p; fl_space = s; fl_perm = pr;
  endtask

  task automatic end_cycle();
    @(negedge clk);
    lk_valid = 0; fl_valid = 0; fsh_all = 0; fsh_ctx_en = 0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] c,
                        input logic [1:0] acc, input logic sup, input string tag);
    set_lookup(va, c, acc, sup, tag);
    end_cycle();
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] c, input logic [18:0] p,
                      input logic [2:0] s, input logic [3:0] pr);
    set_fill(v, c, p, s, pr);
    model_fill(v, c, p, s, pr);
    end_cycle();
  endtask

  task automatic flush_all_op();
    fsh_all = 1;
    for (int i = 0; i < N; i++) mv[i] = 0;
    end_cycle();
  endtask

  task automatic flush_ctx_op(input logic [7:0] c);
    fsh_ctx_en = 1; fsh_ctx = c;
    for (int i = 0; i < N; i++) if (mctx[i] == c) mv[i] = 0;
    end_cycle();
  endtask

  always @(negedge clk) begin
    if (!rst && lk_done) begin
      exp_t  e;
      exp_t  a;
      string t;
      a = '{hit: lk_hit, fault: lk_fault, pav: pa_valid, pa: pa, sp: pa_space};
      if (exp_q.size() == 0) begin
        check(0, "R2", "result without request", 64'(a), 64'(0));
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(a == e, t, "lookup result", 64'(a), 64'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mv[i] = 0; mvpn[i] = 0; mctx[i] = 0; mppn[i] = 0; msp[i] = 0; mprm[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    check({lk_done, lk_hit, lk_fault, pa_valid, pa, pa_space} == '0, "R1", "reset outputs",
          64'({lk_done, lk_hit, lk_fault, pa_valid, pa, pa_space}), 64'(0));
    lookup(32'h0000_0000, 8'd0, 2'd0, 0, "R1");
    end_cycle();
    check(lk_done == 0, "R2", "idle cycle lk_done", 64'(lk_done), 64'(0));

    fill(20'h12345, 8'd3, 19'h4ABCD, 3'd5, 4'h7);
    lookup(32'h1234_5ABC, 8'd3, 2'd0, 0, "R3");
    lookup(32'h1234_5FFF, 8'd3, 2'd1, 0, "R3");
    lookup(32'h1234_5000, 8'd3, 2'd2, 1, "R3");
    lookup(32'h1234_6ABC, 8'd3, 2'd0, 0, "R3");
    lookup(32'h1234_5ABC, 8'd4, 2'd0, 0, "R4");
    fill(20'h12345, 8'd4, 19'h00011, 3'd2, 4'h7);
    lookup(32'h1234_5ABC, 8'd4, 2'd0, 0, "R4");
    lookup(32'h1234_5ABC, 8'd3, 2'd0, 0, "R4");

    fill(20'h00100, 8'd3, 19'h00100, 3'd1, 4'h1);
    lookup(32'h0010_0010, 8'd3, 2'd0, 0, "R5");
    lookup(32'h0010_0010, 8'd3, 2'd1, 0, "R5");
    lookup(32'h0010_0010, 8'd3, 2'd2, 0, "R5");
    lookup(32'h0010_0010, 8'd3, 2'd3, 1, "R5");
    fill(20'h00101, 8'd3, 19'h00200, 3'd6, 4'h9);
    lookup(32'h0010_1020, 8'd3, 2'd0, 0, "R5");
    lookup(32'h0010_1020, 8'd3, 2'd0, 1, "R5");
    lookup(32'h0010_1020, 8'd3, 2'd1, 1, "R5");

    fill(20'h12345, 8'd3, 19'h7FFFF, 3'd7, 4'h3);
    lookup(32'h1234_5123, 8'd3, 2'd1, 0, "R7");

    set_lookup(32'h0020_0000, 8'd3, 2'd0, 0, "R11");
    set_fill(20'h00200, 8'd3, 19'h00333, 3'd4, 4'h1);
    model_fill(20'h00200, 8'd3, 19'h00333, 3'd4, 4'h1);
    end_cycle();
    lookup(32'h0020_0444, 8'd3, 2'd0, 0, "R11");

    fill(20'h00900, 8'd9, 19'h00900, 3'd0, 4'h1);
    flush_ctx_op(8'd3);
    lookup(32'h1234_5123, 8'd3, 2'd0, 0, "R8");
    lookup(32'h0020_0444, 8'd3, 2'd0, 0, "R8");
    lookup(32'h0090_0004, 8'd9, 2'd0, 0, "R8");
    lookup(32'h1234_5ABC, 8'd4, 2'd0, 0, "R8");

    fsh_ctx_en = 1; fsh_ctx = 8'd77;
    set_fill(20'h00A00, 8'd9, 19'h00A00, 3'd0, 4'h1);
    end_cycle();
    lookup(32'h00A0_0000, 8'd9, 2'd0, 0, "R9");
    flush_all_op();
    lookup(32'h0090_0004, 8'd9, 2'd0, 0, "R8");
    fsh_all = 1;
    for (int i = 0; i < N; i++) mv[i] = 0;
    set_fill(20'h00B00, 8'd9, 19'h00B00, 3'd0, 4'h1);
    end_cycle();
    lookup(32'h00B0_0000, 8'd9, 2'd0, 0, "R9");

    for (int i = 0; i < N; i++)
      fill(20'h01000 + 20'(i), (i == 5 || i == 9) ? 8'd7 : 8'd1, 19'h10000 + 19'(i), 3'(i), 4'h1);
    flush_ctx_op(8'd7);
    fill(20'h02000, 8'd1, 19'h20000, 3'd1, 4'h1);
    fill(20'h02001, 8'd1, 19'h20001, 3'd2, 4'h1);
    fill(20'h02002, 8'd1, 19'h20002, 3'd3, 4'h1);
    lookup(32'h0100_0000, 8'd1, 2'd0, 0, "R6");
    lookup(32'h0100_1000, 8'd1, 2'd0, 0, "R6");
    lookup(32'h0200_0000, 8'd1, 2'd0, 0, "R6");
    lookup(32'h0200_1000, 8'd1, 2'd0, 0, "R6");
    lookup(32'h0200_2000, 8'd1, 2'd0, 0, "R6");
    for (int i = 0; i < 40; i++)
      fill(20'h03000 + 20'(i), 8'd2, 19'h30000 + 19'(i), 3'd0, 4'h1);
    for (int i = 0; i < 40; i++)
      lookup({20'h03000 + 20'(i), 12'h0}, 8'd2, 2'd0, 0, "R6");
    lookup(32'h0200_0000, 8'd1, 2'd0, 0, "R6");
    lookup(32'h0200_2000, 8'd1, 2'd0, 0, "R6");
    for (int i = 0; i < N; i++)
      lookup({mvpn[i], 12'h0}, mctx[i], 2'd0, 0, "R10");

    repeat (3) end_cycle();
    check(exp_q.size() == 0, "R2", "pending results", 64'(exp_q.size()), 64'(0));
    finish_run();
  end
endmodule